// File: doc/BRIEF.md
# Block-Based Write/Read Traffic Sequencer

This block orders the commands of a memory test into blocks. A start pulse latches a configuration. The block then runs a number of loops. Each loop is one block: a run of write commands, then at once a run of read commands. Each command can be issued several times in a row to the same address. A burst length goes with every command. When the burst length is above one, every repeat count is taken as one.

The sequencer presents each command on a valid/ready handshake toward the controller. It pulses `addr_adv` when the address generator must move to its next address, and `data_adv` when the data generator must supply its next write word. It does not compute addresses or data, and it does not compare read data. After the final read of the final loop is accepted it pulses `done` for one cycle and returns to idle.

The state machine has four states. ST_IDLE waits for start. ST_WRITE and ST_READ issue commands. ST_DONE is the single-cycle completion state. The transitions are:
- idle to write on an accepted start;
- write to read when the last repeat of the last write is accepted;
- read to write when the last read is accepted and loops remain;
- read to done when the last read of the final loop is accepted;
- done to idle unconditionally.

Top module: `tseq_top`

## Requirements
- R1: After start, the block issues `cfg_loops` blocks. Each block is the block's writes (`cmd_write`=1), followed directly by its reads (`cmd_write`=0).
- R2: Each command is issued repeat-count times in a row. The counts are `cfg_wr_rep` for writes and `cfg_rd_rep` for reads. `addr_adv` is high on the handshake of the last repeat only.
- R3: `cmd_burst` carries the latched burst length. When that length exceeds 1, each command is issued once, whatever the repeat settings.
- R4: Counters advance only on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, `cmd_valid` and `cmd_write` hold.
- R5: `done` is high for exactly one cycle, in the cycle after the last read of the final loop is accepted. After that, `cmd_valid` and `busy` are low.
- R6: A start pulse while `busy` is high is ignored. Configuration inputs that change during a run have no effect on that run.
- R7: When start is sampled, a zero loop count, per-block count, repeat count or burst length is raised to 1.
- R8: When start is sampled, the per-block write and read counts are capped at 4094 with `cfg_masked`=0, and at 255 with `cfg_masked`=1.
- R9: `data_adv` is high on every accepted write handshake, repeats included, and on no read handshake.
- R10: Out of reset, `cmd_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled in idle |
| cfg_loops | input | 12 | Number of blocks |
| cfg_wr_per_blk | input | 12 | Writes per block |
| cfg_rd_per_blk | input | 12 | Reads per block |
| cfg_wr_rep | input | 8 | Issues per write command |
| cfg_rd_rep | input | 8 | Issues per read command |
| cfg_burst_len | input | 8 | Burst length per command |
| cfg_masked | input | 1 | Masked addressing selects the lower cap |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_valid | output | 1 | Command present |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_burst | output | 8 | Burst length of the command |
| addr_adv | output | 1 | Advance the address generator |
| data_adv | output | 1 | Advance the write data generator |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after five corner cases.
- Repeat boundaries with random backpressure. A design that advanced on valid alone, or that dropped a held command, would lose or duplicate scoreboard items.
- A burst length above one with large repeat settings. A sequencer that ignored the override would emit extra commands per address.
- Zero and over-range counts, masked and unmasked. Missing clamps would give empty runs or 4095-long phases.
- A second start, with changed configuration, in the middle of a run. A design that restarted or re-latched would produce a mismatched command stream.
- The cycle after the final read. An off-by-one completion would show `done` a cycle early or late, or for two cycles.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    parameter int LOOP_W  = 12;
    parameter int CNT_W   = 12;
    parameter int REP_W   = 8;
    parameter int BURST_W = 8;
    parameter int MASK_CAP = 255;

    localparam int OPEN_CAP = (1 << CNT_W) - 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [LOOP_W-1:0]  loops;
        logic [CNT_W-1:0]   wr_per;
        logic [CNT_W-1:0]   rd_per;
        logic [REP_W-1:0]   wr_rep;
        logic [REP_W-1:0]   rd_rep;
        logic [BURST_W-1:0] burst;
    } seq_cfg_t;
endpackage

// File: rtl/tseq_cfg_clamp.sv
module tseq_cfg_clamp
    import tseq_pkg::*;
(
    input  logic [LOOP_W-1:0]  loops_in,
    input  logic [CNT_W-1:0]   wr_per_in,
    input  logic [CNT_W-1:0]   rd_per_in,
    input  logic [REP_W-1:0]   wr_rep_in,
    input  logic [REP_W-1:0]   rd_rep_in,
    input  logic [BURST_W-1:0] burst_in,
    input  logic               masked,
    output seq_cfg_t           cfg_out
);
    localparam logic [CNT_W-1:0] CAP_M = CNT_W'(MASK_CAP);
    localparam logic [CNT_W-1:0] CAP_O = CNT_W'(OPEN_CAP);

    function automatic logic [CNT_W-1:0] fit_count(input logic [CNT_W-1:0] v,
                                                   input logic m);
        logic [CNT_W-1:0] cap;
        cap = m ? CAP_M : CAP_O;
        if (v == '0)
            return CNT_W'(1);
        else if (v > cap)
            return cap;
        else
            return v;
    endfunction

    function automatic logic [REP_W-1:0] fit_rep(input logic [REP_W-1:0] v,
                                                 input logic burst_multi);
        if (burst_multi || v == '0)
            return REP_W'(1);
        else
            return v;
    endfunction

    logic [BURST_W-1:0] burst_fit;

    always_comb begin
        burst_fit       = (burst_in == '0) ? BURST_W'(1) : burst_in;
        cfg_out.loops   = (loops_in == '0) ? LOOP_W'(1) : loops_in;
        cfg_out.wr_per  = fit_count(wr_per_in, masked);
        cfg_out.rd_per  = fit_count(rd_per_in, masked);
        cfg_out.wr_rep  = fit_rep(wr_rep_in, burst_fit > BURST_W'(1));
        cfg_out.rd_rep  = fit_rep(rd_rep_in, burst_fit > BURST_W'(1));
        cfg_out.burst   = burst_fit;
    end

    // R8
    always_comb begin
        per_cap_chk: assert (cfg_out.wr_per <= (masked ? CAP_M : CAP_O)
                             && cfg_out.rd_per <= (masked ? CAP_M : CAP_O));
    end
endmodule

// File: rtl/tseq_wrap_cnt.sv
module tseq_wrap_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] count_q;

    assign last = (count_q == limit - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (inc)
            count_q <= last ? '0 : count_q + W'(1);
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < limit);
endmodule

// File: rtl/tseq_top.sv
module tseq_top
    import tseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LOOP_W-1:0]  cfg_loops,
    input  logic [CNT_W-1:0]   cfg_wr_per_blk,
    input  logic [CNT_W-1:0]   cfg_rd_per_blk,
    input  logic [REP_W-1:0]   cfg_wr_rep,
    input  logic [REP_W-1:0]   cfg_rd_rep,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic               cfg_masked,
    input  logic               cmd_ready,
    output logic               cmd_valid,
    output logic               cmd_write,
    output logic [BURST_W-1:0] cmd_burst,
    output logic               addr_adv,
    output logic               data_adv,
    output logic               busy,
    output logic               done
);
    seq_state_e state_q, state_d;
    seq_cfg_t   cfg_q, cfg_fit;

    logic start_acc, hs;
    logic rep_last, cmd_last, loop_last;
    logic [REP_W-1:0] rep_limit;
    logic [CNT_W-1:0] per_limit;

    tseq_cfg_clamp i_clamp (
        .loops_in  (cfg_loops),
        .wr_per_in (cfg_wr_per_blk),
        .rd_per_in (cfg_rd_per_blk),
        .wr_rep_in (cfg_wr_rep),
        .rd_rep_in (cfg_rd_rep),
        .burst_in  (cfg_burst_len),
        .masked    (cfg_masked),
        .cfg_out   (cfg_fit)
    );

    assign start_acc = start && (state_q == ST_IDLE);
    assign hs        = cmd_valid && cmd_ready;
    assign rep_limit = (state_q == ST_READ) ? cfg_q.rd_rep : cfg_q.wr_rep;
    assign per_limit = (state_q == ST_READ) ? cfg_q.rd_per : cfg_q.wr_per;

    tseq_wrap_cnt #(.W(REP_W)) i_rep_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .inc(hs), .limit(rep_limit), .last(rep_last)
    );

    tseq_wrap_cnt #(.W(CNT_W)) i_cmd_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .inc(hs && rep_last), .limit(per_limit), .last(cmd_last)
    );

    tseq_wrap_cnt #(.W(LOOP_W)) i_loop_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .inc(hs && rep_last && cmd_last && state_q == ST_READ),
        .limit(cfg_q.loops), .last(loop_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '{default: 1};
        end else begin
            state_q <= state_d;
            if (start_acc)
                cfg_q <= cfg_fit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_WRITE;
            ST_WRITE: if (hs && rep_last && cmd_last) state_d = ST_READ;
            ST_READ:  if (hs && rep_last && cmd_last)
                          state_d = loop_last ? ST_DONE : ST_WRITE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_WRITE: begin cmd_valid = 1'b1; cmd_write = 1'b1; end
            ST_READ:  cmd_valid = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
        cmd_burst = cfg_q.burst;
        addr_adv  = hs && rep_last;
        data_adv  = hs && cmd_write;
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_write));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !cmd_valid && !busy);

    // R3
    burst_norep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs && cmd_burst > BURST_W'(1) |-> addr_adv);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);

    // R1
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |=> !cmd_valid || !cmd_write
                                    || $past(addr_adv));
endmodule

// File: tb/test_tseq_top.sv
module test_tseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_loops = '0, cfg_wr_per_blk = '0, cfg_rd_per_blk = '0;
    logic [7:0]  cfg_wr_rep = '0, cfg_rd_rep = '0, cfg_burst_len = '0;
    logic        cfg_masked = 1'b0;
    logic        cmd_ready = 1'b1;
    logic        cmd_valid, cmd_write, addr_adv, data_adv, busy, done;
    logic [7:0]  cmd_burst;

    typedef struct {
        logic       wr;
        logic [7:0] burst;
        logic       adv;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   rand_ready = 0;
    bit   prev_stall = 0;
    logic prev_wr = 0;

    always #5 clk = ~clk;

    tseq_top i_tseq_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_loops(cfg_loops), .cfg_wr_per_blk(cfg_wr_per_blk),
        .cfg_rd_per_blk(cfg_rd_per_blk), .cfg_wr_rep(cfg_wr_rep),
        .cfg_rd_rep(cfg_rd_rep), .cfg_burst_len(cfg_burst_len),
        .cfg_masked(cfg_masked), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
        .addr_adv(addr_adv), .data_adv(data_adv), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string msg,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1 cmd_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(cmd_valid && cmd_write == prev_wr, "R4",
                      "command not held under stall", int'(cmd_valid), 1);
            prev_stall = cmd_valid && !cmd_ready;
            prev_wr    = cmd_write;
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1", "unexpected command", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmd_write == e.wr, "R1", "write/read order",
                          int'(cmd_write), int'(e.wr));
                    check(cmd_burst == e.burst, "R3", "burst length",
                          int'(cmd_burst), int'(e.burst));
                    check(addr_adv == e.adv, "R2", "address advance",
                          int'(addr_adv), int'(e.adv));
                    check(data_adv == e.wr, "R9", "data advance",
                          int'(data_adv), int'(e.wr));
                end
            end
        end
    end

    function automatic int fit_cnt(input int v, input bit m);
        int cap;
        cap = m ? 255 : 4094;
        if (v == 0) return 1;
        if (v > cap) return cap;
        return v;
    endfunction

    task automatic run(input int lp, input int wp, input int rp, input int wr,
                       input int rr, input int bl, input bit m,
                       input bit rnd, input bit poke);
        int lpe, wpe, rpe, wre, rre, ble;
        lpe = (lp == 0) ? 1 : lp;
        wpe = fit_cnt(wp, m);
        rpe = fit_cnt(rp, m);
        ble = (bl == 0) ? 1 : bl;
        wre = (ble > 1 || wr == 0) ? 1 : wr;
        rre = (ble > 1 || rr == 0) ? 1 : rr;
        for (int l = 0; l < lpe; l++) begin
            for (int c = 0; c < wpe; c++)
                for (int r = 0; r < wre; r++)
                    exp_q.push_back('{1'b1, 8'(ble), r == wre - 1});
            for (int c = 0; c < rpe; c++)
                for (int r = 0; r < rre; r++)
                    exp_q.push_back('{1'b0, 8'(ble), r == rre - 1});
        end
        rand_ready = rnd;
        @(posedge clk); #2;
        cfg_loops = 12'(lp); cfg_wr_per_blk = 12'(wp); cfg_rd_per_blk = 12'(rp);
        cfg_wr_rep = 8'(wr); cfg_rd_rep = 8'(rr); cfg_burst_len = 8'(bl);
        cfg_masked = m; start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        if (poke) begin
            repeat (4) @(posedge clk);
            #2 start = 1'b1;
            cfg_loops = 12'd7; cfg_wr_per_blk = 12'd9; cfg_burst_len = 8'd3;
            @(posedge clk); #2 start = 1'b0;
        end
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        check(done == 1'b1 && cmd_valid == 1'b0, "R5", "done after last read",
              int'(done), 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0 && cmd_valid == 1'b0, "R5",
              "return to idle", int'(done), 0);
        rand_ready = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!cmd_valid && !busy && !done, "R10", "reset outputs",
              int'(cmd_valid) + int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!cmd_valid && !busy && !done, "R10", "idle after reset",
              int'(busy), 0);
        run(2, 3, 3, 2, 1, 1, 0, 0, 0);       // R1 R2 basic
        run(3, 2, 4, 1, 3, 1, 0, 1, 0);       // R4 backpressure
        run(2, 2, 2, 5, 7, 4, 0, 1, 0);       // R3 burst overrides repeats
        run(0, 0, 0, 0, 0, 0, 0, 0, 0);       // R7 zero clamp
        run(1, 300, 256, 1, 1, 1, 1, 0, 0);   // R8 masked cap
        run(1, 4095, 1, 1, 1, 1, 0, 0, 0);    // R8 open cap
        run(2, 3, 2, 2, 2, 1, 0, 1, 1);       // R6 start ignored while busy
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule